// File: doc/BRIEF.md
# Double-Late-Write Burst SRAM

This block is a single-data-rate synchronous static memory with one data path shared by reads and writes. Every input is captured on the rising clock edge. A read is pipelined through a registered output stage, so its data appears one full cycle after the array access. A write supplies only its address and byte enables with the command. Its data follows on the data input two cycles later, and the block holds each in-flight write in a small queue until that data arrives.

An advance input chooses between loading a fresh command and continuing the current burst. A continuation reuses the burst's read or write type and steps the two low address bits in linear order, wrapping inside a four-word window. A burst ends after a parameterized number of beats. Reads see queued writes through per-byte forwarding, so a read always returns the newest value, even when the write data has not yet reached the array.

The bidirectional pad sits outside the block. The block exposes separate input and output data buses plus an output enable that is high only in cycles carrying read data.

Top module: `dlw_sram`

## Requirements
- R1: While `rst` is high and in the cycle after it, `dq_oe` is 0 and `dq_out` is 0.
- R2: A read loaded at rising edge t (`adv`=0, `en`=1, `we`=0) presents its data on `dq_out` with `dq_oe`=1 after edge t+1, for exactly one cycle.
- R3: A write loaded at edge t (`adv`=0, `en`=1, `we`=1) stores the value present on `dq_in` at edge t+2. The `dq_in` value at other edges is not stored.
- R4: Byte enable bit i of `bwe`, sampled with the command, controls data bits [8i+7:8i]. Lanes whose bit is 0 keep their previous contents.
- R5: Each continuation beat (`adv`=1) uses the previous beat's address with bits [1:0] incremented modulo 4 and the upper bits unchanged.
- R6: A burst holds at most BURST_LEN beats, counting the loading beat. A further `adv`=1 cycle performs no read and no write.
- R7: A continuation beat keeps the read or write type of the burst's loading command. `en` and `we` are ignored while `adv`=1.
- R8: A read returns, per byte lane, the data of the newest earlier write to that address and lane, including writes whose data is still queued.
- R9: `dq_oe` is 1 only in cycles carrying read data, and `dq_out` is 0 in every other cycle. After a deselect, the bus is released once the last read has drained.
- R10: `adv`=1 after a deselect, or after a reset, performs no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Select for a loading cycle; 0 with `adv`=0 deselects |
| we | input | 1 | 1 = write, 0 = read, sampled on loading cycles |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| addr | input | ADDR_W | Word address for loading cycles |
| bwe | input | NUM_BYTES | Per-lane write enables, sampled with each write beat |
| dq_in | input | NUM_BYTES*BYTE_W | Write data, two cycles after its command |
| dq_out | output | NUM_BYTES*BYTE_W | Registered read data |
| dq_oe | output | 1 | High while `dq_out` carries read data |

## Verification
The hard collision is a read whose address matches one or two queued writes. In that case the same rising edge both captures write data from `dq_in` and latches forwarded data into the output register. The bench provokes this with a sweep of writes followed by a read of the same address at gaps of zero and one idle cycles, using every byte-enable pattern on the second write. A long pseudo-random run over eight addresses adds further collisions. Each read result is judged against a bench memory that applies every write in issue order as its data arrives. Since all writes issued before a read have their data by the time that read's output is sampled, the expected value needs no knowledge of the queue.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Linear step of the two-bit burst window, wrapping 3 -> 0.
  function automatic logic [1:0] burst_step(input logic [1:0] lo);
    return lo + 2'd1;
  endfunction

endpackage

// File: rtl/dlw_burst_ctl.sv
module dlw_burst_ctl
  import dlw_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BURST_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 we,
  input  logic                 adv,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BYTES-1:0] bwe,
  output op_e                  cmd_op,
  output logic [ADDR_W-1:0]    cmd_addr,
  output logic [NUM_BYTES-1:0] cmd_be,
  output logic                 burst_cont
);

  localparam int CW = $clog2(BURST_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(BURST_LEN);

  logic              act_q;
  logic              wr_q;
  logic [ADDR_W-1:0] cur_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] next_addr;

  assign next_addr = {cur_q[ADDR_W-1:2], burst_step(cur_q[1:0])};

  always_comb begin
    cmd_op     = OP_IDLE;
    cmd_addr   = addr;
    cmd_be     = bwe;
    burst_cont = 1'b0;
    if (!adv) begin
      if (en) cmd_op = we ? OP_WRITE : OP_READ;
    end else if (act_q && (cnt_q < LAST)) begin
      cmd_op     = wr_q ? OP_WRITE : OP_READ;
      cmd_addr   = next_addr;
      burst_cont = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      cur_q <= '0;
      cnt_q <= '0;
    end else if (!adv) begin
      act_q <= en;
      wr_q  <= we;
      cur_q <= addr;
      cnt_q <= CW'(1);
    end else if (burst_cont) begin
      cur_q <= next_addr;
      cnt_q <= cnt_q + CW'(1);
    end else begin
      act_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dlw_write_queue.sv
module dlw_write_queue
  import dlw_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  op_e                         cmd_op,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic [NUM_BYTES-1:0]        cmd_be,
  input  logic [NUM_BYTES*BYTE_W-1:0] dq_in,
  output logic                        arr_we,
  output logic [ADDR_W-1:0]           arr_addr,
  output logic [NUM_BYTES-1:0]        arr_be,
  output logic [NUM_BYTES-1:0]        byp_new,
  output logic [NUM_BYTES-1:0]        byp_old,
  output logic [NUM_BYTES*BYTE_W-1:0] old_data
);

  localparam int DW = NUM_BYTES * BYTE_W;

  // Stage 0: write issued one edge ago; stage 1: two edges ago.
  logic                 s0_v, s1_v;
  logic [ADDR_W-1:0]    s0_a, s1_a;
  logic [NUM_BYTES-1:0] s0_be, s1_be;
  logic [NUM_BYTES-1:0] hit0, hit1;

  generate
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_match
      assign hit0[i] = s0_v && (s0_a == cmd_addr) && s0_be[i];
      assign hit1[i] = s1_v && (s1_a == cmd_addr) && s1_be[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      s0_v     <= 1'b0;
      s1_v     <= 1'b0;
      s0_a     <= '0;
      s1_a     <= '0;
      s0_be    <= '0;
      s1_be    <= '0;
      byp_new  <= '0;
      byp_old  <= '0;
      old_data <= '0;
    end else begin
      s0_v  <= (cmd_op == OP_WRITE);
      s0_a  <= cmd_addr;
      s0_be <= cmd_be;
      s1_v  <= s0_v;
      s1_a  <= s0_a;
      s1_be <= s0_be;
      if (cmd_op == OP_READ) begin
        byp_new  <= hit0;
        byp_old  <= hit1;
        old_data <= dq_in;
      end else begin
        byp_new  <= '0;
        byp_old  <= '0;
        old_data <= DW'(0);
      end
    end
  end

  assign arr_we   = s1_v;
  assign arr_addr = s1_a;
  assign arr_be   = s1_be;

endmodule

// File: rtl/dlw_array.sv
module dlw_array #(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 8
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           waddr,
  input  logic [NUM_BYTES-1:0]        wbe,
  input  logic [NUM_BYTES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]           raddr,
  output logic [NUM_BYTES*BYTE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
      logic [BYTE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (we && wbe[i]) mem[waddr] <= wdata[i*BYTE_W +: BYTE_W];
        rdata[i*BYTE_W +: BYTE_W] <= mem[raddr];
      end
    end
  endgenerate

endmodule

// File: rtl/dlw_sram.sv
module dlw_sram
  import dlw_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 8,
  parameter int BURST_LEN = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        we,
  input  logic                        adv,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_BYTES-1:0]        bwe,
  input  logic [NUM_BYTES*BYTE_W-1:0] dq_in,
  output logic [NUM_BYTES*BYTE_W-1:0] dq_out,
  output logic                        dq_oe
);

  localparam int DW = NUM_BYTES * BYTE_W;

  op_e                  cmd_op;
  logic [ADDR_W-1:0]    cmd_addr;
  logic [NUM_BYTES-1:0] cmd_be;
  logic                 burst_cont;
  logic                 cmd_rd, cmd_wr;
  logic                 arr_we;
  logic [ADDR_W-1:0]    arr_addr;
  logic [NUM_BYTES-1:0] arr_be;
  logic [NUM_BYTES-1:0] byp_new, byp_old;
  logic [DW-1:0]        old_data;
  logic [DW-1:0]        mem_q;
  logic [DW-1:0]        merged;
  logic                 rd_v1;

  assign cmd_rd = (cmd_op == OP_READ);
  assign cmd_wr = (cmd_op == OP_WRITE);

  dlw_burst_ctl #(
    .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BURST_LEN(BURST_LEN)
  ) u_ctl (
    .clk(clk), .rst(rst), .en(en), .we(we), .adv(adv), .addr(addr), .bwe(bwe),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_be(cmd_be), .burst_cont(burst_cont)
  );

  dlw_write_queue #(
    .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)
  ) u_wq (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_be(cmd_be),
    .dq_in(dq_in), .arr_we(arr_we), .arr_addr(arr_addr), .arr_be(arr_be),
    .byp_new(byp_new), .byp_old(byp_old), .old_data(old_data)
  );

  dlw_array #(
    .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)
  ) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_addr), .wbe(arr_be), .wdata(dq_in),
    .raddr(cmd_addr), .rdata(mem_q)
  );

  // Newest source wins per lane: write issued one edge before the read
  // (its data is on dq_in now), then two edges before, then the array.
  generate
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_merge
      always_comb begin
        if (byp_new[i])
          merged[i*BYTE_W +: BYTE_W] = dq_in[i*BYTE_W +: BYTE_W];
        else if (byp_old[i])
          merged[i*BYTE_W +: BYTE_W] = old_data[i*BYTE_W +: BYTE_W];
        else
          merged[i*BYTE_W +: BYTE_W] = mem_q[i*BYTE_W +: BYTE_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v1  <= 1'b0;
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      rd_v1  <= cmd_rd;
      dq_oe  <= rd_v1;
      dq_out <= rd_v1 ? merged : DW'(0);
    end
  end

endmodule

// File: rtl/dlw_sram_chk.sv
module dlw_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              we,
  input logic              adv,
  input logic              dq_oe,
  input logic              cmd_rd,
  input logic              cmd_wr,
  input logic              arr_we,
  input logic              burst_cont,
  input logic [ADDR_W-1:0] cmd_addr
);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !dq_oe)
    else $error("R1 output enable active after reset");

  p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !adv && !we) |-> ##2 dq_oe)
    else $error("R2 read data not presented two edges later");

  p_write_two_late_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |-> ##2 arr_we)
    else $error("R3 write not committed two edges after command");

  p_burst_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    burst_cont |-> (cmd_addr[ADDR_W-1:2] == $past(cmd_addr[ADDR_W-1:2])) &&
                   (cmd_addr[1:0] == 2'($past(cmd_addr[1:0]) + 2'd1)))
    else $error("R5 burst address not a wrapped linear step");

  p_burst_type_r7: assert property (@(posedge clk) disable iff (rst)
    burst_cont |-> (cmd_wr == $past(cmd_wr)) && (cmd_rd == $past(cmd_rd)))
    else $error("R7 burst beat changed type");

  p_oe_from_read_r9: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(cmd_rd, 2))
    else $error("R9 output enabled without a read");

endmodule

bind dlw_sram dlw_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .we(we), .adv(adv), .dq_oe(dq_oe),
  .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .arr_we(arr_we),
  .burst_cont(burst_cont), .cmd_addr(cmd_addr)
);

// File: tb/tb_dlw_sram.sv
module tb_dlw_sram;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int BL = 4;
  localparam int DW = NB * BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0, we = 1'b0, adv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] bwe = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  always #5 clk = ~clk;

  dlw_sram #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(BW), .BURST_LEN(BL)) dut (
    .clk(clk), .rst(rst), .en(en), .we(we), .adv(adv), .addr(addr), .bwe(bwe),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string cur_req = "R3";

  // Bench model of the memory contents and of the burst rules.
  logic [DW-1:0] ref_mem [1<<AW];
  logic          m_act = 0, m_wr = 0;
  logic [AW-1:0] m_addr = '0;
  int            m_cnt = 0;
  logic          p1_v = 0, p1_wr = 0, p2_v = 0, p2_wr = 0;
  logic [AW-1:0] p1_a = '0, p2_a = '0;
  logic [NB-1:0] p1_be = '0, p2_be = '0;
  logic [31:0]   lfsr = 32'h1ACE_B00C;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic lfsr_step();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic step(input logic e, input logic w, input logic a,
                      input logic [AW-1:0] ad, input logic [NB-1:0] be);
    logic          c_v, c_wr;
    logic [AW-1:0] c_a;
    @(negedge clk);
    en = e; we = w; adv = a; addr = ad; bwe = be;
    lfsr_step();
    dq_in = (p2_v && p2_wr) ? lfsr : ~lfsr;   // garbage when no data is due
    c_v = 0; c_wr = 0; c_a = ad;
    if (!a) begin
      c_v = e; c_wr = w;
      m_act = e; m_wr = w; m_addr = ad; m_cnt = 1;
    end else if (m_act && m_cnt < BL) begin
      c_v = 1; c_wr = m_wr;
      c_a = {m_addr[AW-1:2], 2'(m_addr[1:0] + 2'd1)};
      m_addr = c_a; m_cnt++;
    end else begin
      m_act = 0;
    end
    @(posedge clk);
    #1;
    if (p2_v && p2_wr)
      for (int l = 0; l < NB; l++)
        if (p2_be[l]) ref_mem[p2_a][l*BW +: BW] = dq_in[l*BW +: BW];
    chk({cur_req, "/R9 oe"}, DW'(dq_oe), DW'(p1_v && !p1_wr));
    if (p1_v && !p1_wr) chk({cur_req, " data"}, dq_out, ref_mem[p1_a]);
    else                chk({cur_req, "/R9 idle bus"}, dq_out, '0);
    p2_v = p1_v; p2_wr = p1_wr; p2_a = p1_a; p2_be = p1_be;
    p1_v = c_v;  p1_wr = c_wr;  p1_a = c_a;  p1_be = be;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 oe in reset", DW'(dq_oe), '0);
    chk("R1 data in reset", dq_out, '0);
    @(negedge clk);
    rst = 0;
    @(posedge clk);
    #1;
    chk("R1 oe after reset", DW'(dq_oe), '0);
    chk("R1 data after reset", dq_out, '0);

    // R10: advance straight after reset is a no-op
    cur_req = "R10";
    step(0, 1, 1, 6'd3, 4'hF);
    step(0, 0, 1, 6'd3, 4'hF);
    idle(2);

    // R3: fill every word back to back, then read all back to back
    cur_req = "R3";
    for (int a = 0; a < (1 << AW); a++) step(1, 1, 0, AW'(a), 4'hF);
    idle(2);
    for (int a = 0; a < (1 << AW); a++) step(1, 0, 0, AW'(a), '0);
    idle(2);

    // R2: isolated read, then deselect drains the bus
    cur_req = "R2";
    step(1, 0, 0, 6'd17, '0);
    idle(3);

    // R4: every byte-enable pattern
    cur_req = "R4";
    for (int b = 0; b < 16; b++) begin
      step(1, 1, 0, 6'd20, NB'(b));
      idle(2);
      step(1, 0, 0, 6'd20, '0);
      idle(2);
    end

    // R5, R7: bursts from every start offset
    for (int s = 0; s < 4; s++) begin
      cur_req = "R5";
      step(1, 1, 0, AW'(24 + s), 4'hF);
      for (int k = 0; k < BL - 1; k++) step(0, 0, 1, '0, 4'hF);  // we low: type inherited
      idle(2);
      for (int k = 0; k < 4; k++) step(1, 0, 0, AW'(24 + k), '0);
      idle(2);
      cur_req = "R7";
      step(1, 0, 0, AW'(24 + s), '0);
      for (int k = 0; k < BL - 1; k++) step(1, 1, 1, '0, 4'hF);  // we high: still reads
      idle(2);
    end

    // R6: beats beyond the burst length do nothing
    cur_req = "R6";
    step(1, 1, 0, 6'd40, 4'hF);
    for (int k = 0; k < BL + 1; k++) step(1, 1, 1, '0, 4'hF);
    idle(2);
    step(1, 0, 0, 6'd40, '0);
    for (int k = 0; k < BL + 1; k++) step(1, 0, 1, '0, '0);
    idle(2);
    for (int k = 0; k < 4; k++) step(1, 0, 0, AW'(40 + k), '0);
    idle(2);

    // R10: advance after a deselect is a no-op
    cur_req = "R10";
    step(1, 1, 0, 6'd45, 4'hF);
    step(0, 0, 0, '0, '0);
    step(1, 1, 1, '0, 4'hF);
    step(1, 0, 1, '0, 4'hF);
    idle(2);
    step(1, 0, 0, 6'd45, '0);
    step(1, 0, 0, 6'd46, '0);
    idle(2);

    // R8: reads colliding with one or two queued writes
    cur_req = "R8";
    for (int b = 0; b < 16; b++)
      for (int g = 0; g < 2; g++) begin
        step(1, 1, 0, 6'd50, 4'hF);
        step(1, 1, 0, 6'd50, NB'(b));
        idle(g);
        step(1, 0, 0, 6'd50, '0);
        idle(2);
      end

    // R8: pseudo-random mix over a few addresses
    for (int i = 0; i < 3000; i++) begin
      lfsr_step();
      step(lfsr[2] | lfsr[3], lfsr[4], lfsr[0] & lfsr[1],
           {lfsr[10], 3'b000, lfsr[6:5]}, lfsr[14:11]);
    end
    idle(3);

    finish_run();
  end

endmodule